// File: doc/BRIEF.md
# Pin Input Debounce Filter with Shared Sample Divider

This block sits between the raw input pins of a 32-pin general-purpose bank and the logic that consumes them (edge and level interrupt detection, and the register that reports pin levels). Each pin can be opted into debouncing. A debounced pin only adopts a new level once that level has been seen on two consecutive sample strobes. Pins that are not opted in reach the output unchanged and with no delay.

All pins that use the slow sample rate share one programmable counter. The counter divides the reference clock down to a sample strobe. A build parameter picks between two variants: a strobe period of (div+1) cycles, or twice that. A pin that has debouncing on but its divided-clock enable off is sampled on every reference clock cycle, so it rejects only single-cycle glitches.

The divider is a two-state machine. In `DIV_IDLE` the count is held at zero and no strobe is produced. It moves to `DIV_RUN` once any pin has both of its enables set. In `DIV_RUN` the count rises by one each cycle, and on the cycle it reaches the limit it issues a strobe and wraps to zero. It returns to `DIV_IDLE`, clearing the count, once no pin has both enables set. Configuration is loaded through a simple register write port and can be read back combinationally.

Top module: `pin_debounce_bank`

## Requirements
- R1: After reset every configuration register reads zero and, with all inputs low, `pin_filt` is all zero.
- R2: Debounce enables live at 0x38 (pins 15..0) and 0x3C (pins 31..16); divided-clock enables live at 0x40 (pins 15..0) and 0x44 (pins 31..16). A write updates bit j of the addressed half only where `wr_data[16+j]` is 1, taking the value from `wr_data[j]`. A read returns the half in bits 15..0 with bits 31..16 zero.
- R3: The divider value at 0x48 is written as a plain word. Bits 23..0 are kept, bits 31..24 are ignored and read as zero, and any unmapped address reads zero.
- R4: A pin whose debounce enable is 0 drives `pin_filt` equal to `pin_raw` in the same cycle, including right after its enable is cleared.
- R5: A pin with debounce enable 1 and divided-clock enable 0 is sampled every cycle, so a raw change appears on `pin_filt` exactly two clock edges later.
- R6: With the divider running, the sample period P is div+1 cycles when `SLOW_STROBE`=0 and 2*(div+1) cycles when `SLOW_STROBE`=1. On a divided-clock pin, a raw change held steady reaches `pin_filt` between P+1 and 2P edges after it occurs, and the filtered level moves only on a strobe.
- R7: A filtered pin adopts a level only when two consecutive samples both show it. A pulse shorter than P cycles on a divided-clock pin never reaches `pin_filt`.
- R8: While no pin has both enables set, the divider count stays zero. After the write that sets the first pair of enables, the first strobe falls on edge P+1 after that write edge, so a raw change applied just after the write reaches `pin_filt` on edge 2P+1.
- R9: Each pin filters on its own. Activity on one debounced pin, including one in the upper half, leaves every other pin's filtered level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also the sample and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the register written |
| wr_data | input | 32 | Write data (mask in bits 31..16 for the enable halves) |
| rd_addr | input | 8 | Byte address of the register read |
| rd_data | output | 32 | Combinational read data |
| pin_raw | input | 32 | Pin levels, already synchronized to `clk` |
| pin_filt | output | 32 | Debounced or passed-through pin levels |

## Verification
The assertions assume that `pin_raw` is already synchronous to `clk`, with any metastability filtering done upstream, and that only one register access happens per cycle. The bench meets this by changing `pin_raw`, the write port and `rd_addr` only at falling clock edges, one write at a time. Every divider value the bench programs gives a period of at least two cycles whenever a glitch-rejection result is expected, since a one-cycle period cannot separate a pulse from a level.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

    // Register byte offsets; software relies on these positions.
    localparam logic [7:0] OFS_DBN_LO = 8'h38;
    localparam logic [7:0] OFS_DBN_HI = 8'h3C;
    localparam logic [7:0] OFS_CKE_LO = 8'h40;
    localparam logic [7:0] OFS_CKE_HI = 8'h44;
    localparam logic [7:0] OFS_DIV    = 8'h48;

    // Shared sample divider states.
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_t;

endpackage

// File: rtl/pdb_regs.sv
module pdb_regs
    import pdb_pkg::*;
#(
    parameter int PIN_W  = 32,
    parameter int DIV_W  = 24,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PIN_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PIN_W-1:0]  rd_data,
    output logic [PIN_W-1:0]  dbn_en,
    output logic [PIN_W-1:0]  cke_en,
    output logic [DIV_W-1:0]  div_val
);

    localparam int HALF = PIN_W / 2;

    localparam logic [ADDR_W-1:0] A_DBN_LO = ADDR_W'(OFS_DBN_LO);
    localparam logic [ADDR_W-1:0] A_DBN_HI = ADDR_W'(OFS_DBN_HI);
    localparam logic [ADDR_W-1:0] A_CKE_LO = ADDR_W'(OFS_CKE_LO);
    localparam logic [ADDR_W-1:0] A_CKE_HI = ADDR_W'(OFS_CKE_HI);
    localparam logic [ADDR_W-1:0] A_DIV    = ADDR_W'(OFS_DIV);

    logic [PIN_W-1:0] dbn_q, dbn_nx;
    logic [PIN_W-1:0] cke_q, cke_nx;
    logic [DIV_W-1:0] div_q, div_nx;

    // Upper half of the write word selects which lower-half bits change.
    function automatic logic [HALF-1:0] merge_half(
        input logic [HALF-1:0]  old_v,
        input logic [PIN_W-1:0] d
    );
        logic [HALF-1:0] r;
        for (int j = 0; j < HALF; j++) begin
            r[j] = d[HALF+j] ? d[j] : old_v[j];
        end
        return r;
    endfunction

    always_comb begin
        dbn_nx = dbn_q;
        cke_nx = cke_q;
        div_nx = div_q;
        if (wr_en) begin
            case (wr_addr)
                A_DBN_LO: dbn_nx[HALF-1:0]     = merge_half(dbn_q[HALF-1:0], wr_data);
                A_DBN_HI: dbn_nx[PIN_W-1:HALF] = merge_half(dbn_q[PIN_W-1:HALF], wr_data);
                A_CKE_LO: cke_nx[HALF-1:0]     = merge_half(cke_q[HALF-1:0], wr_data);
                A_CKE_HI: cke_nx[PIN_W-1:HALF] = merge_half(cke_q[PIN_W-1:HALF], wr_data);
                A_DIV:    div_nx               = wr_data[DIV_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbn_q <= '0;
            cke_q <= '0;
            div_q <= '0;
        end else begin
            dbn_q <= dbn_nx;
            cke_q <= cke_nx;
            div_q <= div_nx;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_DBN_LO: rd_data[HALF-1:0]  = dbn_q[HALF-1:0];
            A_DBN_HI: rd_data[HALF-1:0]  = dbn_q[PIN_W-1:HALF];
            A_CKE_LO: rd_data[HALF-1:0]  = cke_q[HALF-1:0];
            A_CKE_HI: rd_data[HALF-1:0]  = cke_q[PIN_W-1:HALF];
            A_DIV:    rd_data[DIV_W-1:0] = div_q;
            default:  ;
        endcase
    end

    assign dbn_en  = dbn_q;
    assign cke_en  = cke_q;
    assign div_val = div_q;

endmodule

// File: rtl/pdb_divider.sv
module pdb_divider
    import pdb_pkg::*;
#(
    parameter int DIV_W       = 24,
    parameter bit SLOW_STROBE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick,
    output logic [DIV_W:0]   cnt_o
);

    localparam int CNT_W = DIV_W + 1;

    div_state_t       state_q, state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Variant choice: terminal count div or 2*div+1.
    generate
        if (SLOW_STROBE) begin : g_slow
            assign limit = {div_val, 1'b1};
        end else begin : g_fast
            assign limit = {1'b0, div_val};
        end
    endgenerate

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIV_IDLE;
        else        state_q <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            DIV_IDLE: if (run_req)  state_nx = DIV_RUN;
            DIV_RUN:  if (!run_req) state_nx = DIV_IDLE;
            default:  state_nx = DIV_IDLE;
        endcase
    end

    // Outputs: strobe on terminal count while running
    always_comb begin
        tick = 1'b0;
        unique case (state_q)
            DIV_IDLE: tick = 1'b0;
            DIV_RUN:  tick = run_req && (cnt_q >= limit);
            default:  tick = 1'b0;
        endcase
    end

    // Counter: zero outside DIV_RUN, wraps after each strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == DIV_RUN && run_req) begin
            cnt_q <= tick ? '0 : cnt_q + CNT_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pdb_pin_filter.sv
module pdb_pin_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic dbn_en_i,
    input  logic cke_en_i,
    input  logic tick_i,
    output logic filt_o,
    output logic hold_o,
    output logic samp_o
);

    logic samp_q;
    logic hold_q;
    logic take;

    // Divided-clock pins wait for the shared strobe; others sample each cycle.
    assign take = cke_en_i ? tick_i : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            hold_q <= 1'b0;
        end else if (!dbn_en_i) begin
            samp_q <= raw_i;
            hold_q <= raw_i;
        end else if (take) begin
            samp_q <= raw_i;
            if (raw_i == samp_q) hold_q <= raw_i;
        end
    end

    assign filt_o = dbn_en_i ? hold_q : raw_i;
    assign hold_o = hold_q;
    assign samp_o = samp_q;

endmodule

// File: rtl/pin_debounce_bank.sv
module pin_debounce_bank
    import pdb_pkg::*;
#(
    parameter int PIN_W       = 32,
    parameter int DIV_W       = 24,
    parameter int ADDR_W      = 8,
    parameter bit SLOW_STROBE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PIN_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PIN_W-1:0]  rd_data,
    input  logic [PIN_W-1:0]  pin_raw,
    output logic [PIN_W-1:0]  pin_filt
);

    logic [PIN_W-1:0] dbn_en_q;
    logic [PIN_W-1:0] cke_en_q;
    logic [DIV_W-1:0] div_val;
    logic             any_run;
    logic             smp_tick;
    logic [DIV_W:0]   div_cnt;
    logic [PIN_W-1:0] filt_vec;
    logic [PIN_W-1:0] samp_vec;

    pdb_regs #(
        .PIN_W (PIN_W),
        .DIV_W (DIV_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .dbn_en (dbn_en_q),
        .cke_en (cke_en_q),
        .div_val(div_val)
    );

    // Divider runs only while some pin uses the divided strobe.
    assign any_run = |(dbn_en_q & cke_en_q);

    pdb_divider #(
        .DIV_W      (DIV_W),
        .SLOW_STROBE(SLOW_STROBE)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_req(any_run),
        .div_val(div_val),
        .tick   (smp_tick),
        .cnt_o  (div_cnt)
    );

    generate
        for (genvar g = 0; g < PIN_W; g++) begin : g_pin
            pdb_pin_filter u_flt (
                .clk     (clk),
                .rst_n   (rst_n),
                .raw_i   (pin_raw[g]),
                .dbn_en_i(dbn_en_q[g]),
                .cke_en_i(cke_en_q[g]),
                .tick_i  (smp_tick),
                .filt_o  (pin_filt[g]),
                .hold_o  (filt_vec[g]),
                .samp_o  (samp_vec[g])
            );
        end
    endgenerate

endmodule

// File: rtl/pdb_checker.sv
module pdb_checker
    import pdb_pkg::*;
#(
    parameter int PIN_W  = 32,
    parameter int DIV_W  = 24,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PIN_W-1:0]  dbn_en,
    input logic [PIN_W-1:0]  cke_en,
    input logic              tick,
    input logic              run_req,
    input logic [DIV_W:0]    cnt,
    input logic [PIN_W-1:0]  filt_q,
    input logic [PIN_W-1:0]  samp_q,
    input logic [PIN_W-1:0]  pin_raw,
    input logic [PIN_W-1:0]  pin_filt,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [PIN_W-1:0]  rd_data
);

    // R4
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_filt ^ pin_raw) & ~dbn_en) == '0);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_req |=> cnt == '0);

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run_req) |=> cnt == '0);

    // R6
    strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ((filt_q ^ $past(filt_q)) & $past(dbn_en & cke_en)) == '0);

    // R7
    two_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt_q ^ $past(filt_q)) & (filt_q ^ $past(samp_q)) & $past(dbn_en)) == '0);

    // R3
    div_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(OFS_DIV)) |-> rd_data[PIN_W-1:DIV_W] == '0);

endmodule

bind pin_debounce_bank pdb_checker #(
    .PIN_W (PIN_W),
    .DIV_W (DIV_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dbn_en  (dbn_en_q),
    .cke_en  (cke_en_q),
    .tick    (smp_tick),
    .run_req (any_run),
    .cnt     (div_cnt),
    .filt_q  (filt_vec),
    .samp_q  (samp_vec),
    .pin_raw (pin_raw),
    .pin_filt(pin_filt),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/tb_pin_debounce_bank.sv
`timescale 1ns/1ps
module tb_pin_debounce_bank;

    localparam bit TB_SLOW = 1'b0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] pin_raw = '0;
    logic [31:0] pin_filt;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    pin_debounce_bank #(.SLOW_STROBE(TB_SLOW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_raw(pin_raw), .pin_filt(pin_filt)
    );

    always #2 clk = ~clk;

    function automatic int period(input int d);
        return TB_SLOW ? 2 * (d + 1) : d + 1;
    endfunction

    task automatic chk32(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input int act, input int lo, input int hi, input string tag);
        n_run++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        rd_addr = a;
        #1;
        chk32(rd_data, exp, tag);
    endtask

    // Optionally flip a pin, then count edges until its filtered level moves.
    task automatic measure(input int b, input bit flip, output int lat);
        logic v;
        v = pin_filt[b];
        if (flip) pin_raw[b] = ~pin_raw[b];
        lat = 0;
        while (pin_filt[b] == v && lat < 300) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk32(pin_filt, 32'h0, "R1 filt after reset");
        rd_chk(8'h38, 32'h0, "R1 dbn lo");
        rd_chk(8'h3C, 32'h0, "R1 dbn hi");
        rd_chk(8'h40, 32'h0, "R1 cke lo");
        rd_chk(8'h44, 32'h0, "R1 cke hi");
        rd_chk(8'h48, 32'h0, "R1 div");
    endtask

    task automatic t_regs;
        wr(8'h38, 32'hFFFF_A5A5);
        rd_chk(8'h38, 32'h0000_A5A5, "R2 full mask write");
        wr(8'h38, 32'h0000_FFFF);
        rd_chk(8'h38, 32'h0000_A5A5, "R2 zero mask ignored");
        wr(8'h38, 32'h000F_0000);
        rd_chk(8'h38, 32'h0000_A5A0, "R2 partial mask");
        wr(8'h3C, 32'h8000_8000);
        rd_chk(8'h3C, 32'h0000_8000, "R2 upper half");
        rd_chk(8'h40, 32'h0, "R2 other reg untouched");
        wr(8'h48, 32'hFF12_3456);
        rd_chk(8'h48, 32'h0012_3456, "R3 divider upper byte dropped");
        rd_chk(8'h4C, 32'h0, "R3 unmapped reads zero");
        wr(8'h38, 32'hFFFF_0000);
        wr(8'h3C, 32'hFFFF_0000);
        wr(8'h48, 32'h0);
    endtask

    task automatic t_pass;
        pin_raw = 32'hDEAD_BEEF; #1;
        chk32(pin_filt, 32'hDEAD_BEEF, "R4 passthrough a");
        pin_raw = 32'h1234_5678; #1;
        chk32(pin_filt, 32'h1234_5678, "R4 passthrough b");
        @(negedge clk);
        pin_raw = 32'h0;
        @(negedge clk);
    endtask

    task automatic t_fast;
        wr(8'h38, 32'h0008_0008);
        pin_raw[3] = 1'b1;
        @(posedge clk); @(negedge clk);
        chk32({31'b0, pin_filt[3]}, 32'h0, "R5 one edge after change");
        @(posedge clk); @(negedge clk);
        chk32({31'b0, pin_filt[3]}, 32'h1, "R5 two edges after change");
    endtask

    task automatic t_start;
        int lat;
        pin_raw[3] = 1'b0;
        repeat (3) @(negedge clk);
        wr(8'h48, 32'd3);
        wr(8'h40, 32'h0008_0008);
        measure(3, 1'b1, lat);
        chk32(lat, 2 * period(3) + 1, "R8 first strobe after idle");
    endtask

    task automatic t_phase;
        int lat;
        for (int k = 0; k < 5; k++) begin
            repeat (k) @(negedge clk);
            measure(3, 1'b1, lat);
            chk_rng(lat, period(3) + 1, 2 * period(3), "R6 latency div=3");
        end
        wr(8'h48, 32'd0);
        repeat (4) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            measure(3, 1'b1, lat);
            chk_rng(lat, period(0) + 1, 2 * period(0), "R6 latency div=0");
        end
        wr(8'h48, 32'd6);
        repeat (20) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            repeat (2 * k) @(negedge clk);
            measure(3, 1'b1, lat);
            chk_rng(lat, period(6) + 1, 2 * period(6), "R6 latency div=6");
        end
    endtask

    task automatic t_glitch;
        logic v;
        bit   bad;
        wr(8'h48, 32'd3);
        repeat (10) @(negedge clk);
        v = pin_filt[3];
        for (int k = 0; k < 4; k++) begin
            bad = 1'b0;
            repeat (k) @(negedge clk);
            pin_raw[3] = ~v;
            repeat (period(3) - 1) @(negedge clk);
            pin_raw[3] = v;
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                if (pin_filt[3] !== v) bad = 1'b1;
            end
            chk32({31'b0, bad}, 32'h0, "R7 short pulse rejected");
        end
    endtask

    task automatic t_multi;
        int   lat;
        logic f3;
        wr(8'h3C, 32'h0010_0010);
        wr(8'h44, 32'h0010_0010);
        repeat (10) @(negedge clk);
        f3 = pin_filt[3];
        measure(20, 1'b1, lat);
        chk_rng(lat, period(3) + 1, 2 * period(3), "R9 upper pin latency");
        chk32({31'b0, pin_filt[3]}, {31'b0, f3}, "R9 neighbour unchanged");
        pin_raw[2] = ~pin_raw[2]; #1;
        chk32({31'b0, pin_filt[2]}, {31'b0, pin_raw[2]}, "R4 plain pin beside filtered ones");
        wr(8'h3C, 32'h0010_0000);
        pin_raw[20] = ~pin_raw[20]; #1;
        chk32({31'b0, pin_filt[20]}, {31'b0, pin_raw[20]}, "R4 passthrough after disable");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_pass;
        t_fast;
        t_start;
        t_phase;
        t_glitch;
        t_multi;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule